// File: doc/BRIEF.md
# Page Load and Commit Controller

This block sits behind a bit-serial memory protocol engine and manages nonvolatile page writes. The engine reports bit-level events: a data bit written, a read cycle, a completed reset sequence, and a completed address load along with the address. After an address load, this block gathers incoming data bits into bytes, most significant bit first. It stores each byte in a page buffer at a running in-page offset, and that offset wraps within the page.

A commit is accepted only under three conditions. A reset sequence must have armed the write-enable latch. The load must end on a byte boundary. The load must be followed by a read / write-1 / read trailer while write protect is high. The commit runs for a programmable number of clock cycles. After that, the block writes every byte that was actually loaded through an array write port, one byte per cycle. A busy flag and its inverse, the ready value that the I/O line shows to a polling host, stay valid for the whole commit. Events that arrive during a commit are ignored.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, the write-enable latch is 0, busy is 0, ready is 1 and the array write strobe is 0.
- R2: A reset-sequence event outside a commit sets the latch in the next cycle. An address load with the latch clear starts no page load.
- R3: Data bits form bytes MSB first. Each eighth bit stores the byte at the current offset, then the offset steps by one. The first offset is the low log2(PAGE_BYTES) bits of the loaded address, and the page base is the upper bits.
- R4: The offset wraps from PAGE_BYTES-1 to 0 within the page, so a byte loaded later overwrites the earlier byte at the same offset.
- R5: Some sequences clear the latch in the next cycle and start no commit: a read after a partial byte, a read after zero bytes, a write of 0 after the closing read, a second read in place of the write of 1, and a data bit in place of the final read.
- R6: If write protect is low at the final trailer read, the commit is blocked and the latch clears. Write protect falling during a running commit does not shorten or abort it.
- R7: Busy goes high in the cycle after the accepted final trailer read and stays high for exactly COMMIT_CYC+PAGE_BYTES+1 cycles. Ready is always the inverse of busy.
- R8: During a commit, only loaded offsets are written to the array, at page base plus offset, with the last byte loaded for that offset. Untouched array bytes keep their values, and the write strobe is never high outside busy.
- R9: The latch clears when a commit finishes. Reset-sequence, address, read and data events during a commit neither alter the commit nor its buffered data.
- R10: A reset-sequence event outside a commit abandons any load or trailer in progress, and bytes from the abandoned load are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_wr_i | input | 1 | One-cycle pulse: a data bit was written |
| bit_val_i | input | 1 | Value of the written bit |
| rd_cyc_i | input | 1 | One-cycle pulse: a read cycle occurred |
| rst_seq_i | input | 1 | One-cycle pulse: a reset sequence completed |
| addr_ld_i | input | 1 | One-cycle pulse: address load completed |
| addr_i | input | ADDR_W | Loaded byte address |
| wp_i | input | 1 | Write protect, low blocks new commits |
| wel_o | output | 1 | Write-enable latch state |
| busy_o | output | 1 | Commit in progress |
| ready_o | output | 1 | Polled status value, 0 while busy |
| arr_we_o | output | 1 | Array write strobe |
| arr_addr_o | output | ADDR_W | Array write address |
| arr_data_o | output | 8 | Array write data |

## Verification
The bench builds the block with an 8-bit address, 8-byte pages and a 6-cycle commit timer. With these values, a ten-byte load wraps the page and overwrites two offsets. A whole commit, including the flush of every page offset, also fits into about fifteen cycles. A behavioural model tracks the latch, the busy window and the expected contents of all 256 array bytes, so partial pages, wrapped pages and abandoned loads can each be compared byte for byte.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_TR1, ST_TR2, ST_HOLD, ST_FLUSH, ST_DRAIN
  } pcc_state_e;
endpackage

// File: rtl/pcc_timer.sv
module pcc_timer #(
  parameter int COMMIT_CYC = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(COMMIT_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(COMMIT_CYC - 1);
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < COMMIT_CYC);
endmodule

// File: rtl/pcc_pagebuf.sv
module pcc_pagebuf #(
  parameter int PAGE_BYTES = 64,
  localparam int OW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [OW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic          clr_i,
  input  logic          rd_i,
  input  logic [OW-1:0] raddr_i,
  output logic [7:0]    rdata_o,
  output logic          rdirty_o
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] dirty_q;
  logic [7:0]            rdata_q;
  logic                  rdirty_q;

  always_ff @(posedge clk) begin
    if (wr_i) mem[waddr_i] <= wdata_i;
    if (rd_i) rdata_q <= mem[raddr_i];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) dirty_q <= '0;
    else if (wr_i) dirty_q[waddr_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rdirty_q <= 1'b0;
    else rdirty_q <= rd_i && dirty_q[raddr_i];
  end

  assign rdata_o  = rdata_q;
  assign rdirty_o = rdirty_q;

  // R9
  no_load_during_flush_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && rd_i));
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pcc_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  localparam int OW = $clog2(PAGE_BYTES),
  localparam int PW = ADDR_W - OW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_wr_i,
  input  logic          bit_val_i,
  input  logic          rd_cyc_i,
  input  logic          rst_seq_i,
  input  logic          addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic          wp_i,
  input  logic          tmr_exp_i,
  output logic          tmr_start_o,
  output logic          tmr_run_o,
  output logic          buf_wr_o,
  output logic [OW-1:0] buf_waddr_o,
  output logic [7:0]    buf_wdata_o,
  output logic          buf_clr_o,
  output logic          buf_rd_o,
  output logic [OW-1:0] buf_raddr_o,
  output logic [PW-1:0] page_o,
  output logic [OW-1:0] idx_d_o,
  output logic          wel_o,
  output logic          busy_o,
  output logic          ready_o
);
  pcc_state_e    st_q;
  logic          wel_q, busy_q, ready_q, any_q;
  logic [2:0]    bcnt_q;
  logic [6:0]    sh_q;
  logic [OW-1:0] ptr_q, idx_q, idx_d_q;
  logic [PW-1:0] page_q;
  logic in_commit, take_rst, take_addr, ev_rd, ev_wb, fail;

  always_comb begin
    in_commit = (st_q == ST_HOLD) || (st_q == ST_FLUSH) || (st_q == ST_DRAIN);
    take_rst  = rst_seq_i && !in_commit;
    take_addr = addr_ld_i && !rst_seq_i && !in_commit;
    ev_rd     = rd_cyc_i && !rst_seq_i && !addr_ld_i;
    ev_wb     = bit_wr_i && !rd_cyc_i && !rst_seq_i && !addr_ld_i;
    fail = ((st_q == ST_LOAD) && ev_rd && !(bcnt_q == 3'd0 && any_q))
        || ((st_q == ST_TR1) && (ev_rd || (ev_wb && !bit_val_i)))
        || ((st_q == ST_TR2) && ((ev_rd && !(wp_i && wel_q)) || ev_wb));
    tmr_start_o = (st_q == ST_TR2) && ev_rd && wp_i && wel_q;
    tmr_run_o   = (st_q == ST_HOLD);
    buf_wr_o    = (st_q == ST_LOAD) && ev_wb && (bcnt_q == 3'd7);
    buf_waddr_o = ptr_q;
    buf_wdata_o = {sh_q, bit_val_i};
    buf_clr_o   = take_rst || (take_addr && wel_q);
    buf_rd_o    = (st_q == ST_FLUSH);
    buf_raddr_o = idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; wel_q <= 1'b0; busy_q <= 1'b0; ready_q <= 1'b1;
      any_q <= 1'b0; bcnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      idx_q <= '0; idx_d_q <= '0; page_q <= '0;
    end else begin
      idx_d_q <= idx_q;
      if (take_rst) begin
        wel_q <= 1'b1;
        st_q  <= ST_IDLE;
      end else if (take_addr) begin
        if (wel_q) begin
          st_q   <= ST_LOAD;
          page_q <= addr_i[ADDR_W-1:OW];
          ptr_q  <= addr_i[OW-1:0];
          bcnt_q <= '0;
          any_q  <= 1'b0;
        end
      end else if (fail) begin
        st_q  <= ST_IDLE;
        wel_q <= 1'b0;
      end else begin
        case (st_q)
          ST_LOAD: begin
            if (ev_rd) st_q <= ST_TR1;
            else if (ev_wb) begin
              sh_q   <= {sh_q[5:0], bit_val_i};
              bcnt_q <= bcnt_q + 3'd1;
              if (bcnt_q == 3'd7) begin
                ptr_q <= ptr_q + 1'b1;
                any_q <= 1'b1;
              end
            end
          end
          ST_TR1: if (ev_wb) st_q <= ST_TR2;
          ST_TR2: if (ev_rd) begin
            st_q <= ST_HOLD; busy_q <= 1'b1; ready_q <= 1'b0;
          end
          ST_HOLD: if (tmr_exp_i) begin
            st_q <= ST_FLUSH; idx_q <= '0;
          end
          ST_FLUSH: begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == OW'(PAGE_BYTES - 1)) st_q <= ST_DRAIN;
          end
          ST_DRAIN: begin
            st_q <= ST_IDLE; busy_q <= 1'b0; ready_q <= 1'b1; wel_q <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assign page_o  = page_q;
  assign idx_d_o = idx_d_q;
  assign wel_o   = wel_q;
  assign busy_o  = busy_q;
  assign ready_o = ready_q;

  // R6
  commit_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(wp_i) && $past(wel_q) && $past(st_q) == ST_TR2));
  // R9
  wel_clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !wel_q);
  // R9
  commit_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && st_q != ST_DRAIN) |=> busy_q);
  // R2
  load_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD) |-> wel_q);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 64,
  parameter int COMMIT_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_wr_i,
  input  logic              bit_val_i,
  input  logic              rd_cyc_i,
  input  logic              rst_seq_i,
  input  logic              addr_ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  output logic              wel_o,
  output logic              busy_o,
  output logic              ready_o,
  output logic              arr_we_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [7:0]        arr_data_o
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = ADDR_W - OW;

  logic          tmr_start, tmr_run, tmr_exp;
  logic          buf_wr, buf_clr, buf_rd;
  logic [OW-1:0] buf_waddr, buf_raddr, idx_d;
  logic [7:0]    buf_wdata;
  logic [PW-1:0] page;

  pcc_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk, .rst, .bit_wr_i, .bit_val_i, .rd_cyc_i, .rst_seq_i, .addr_ld_i,
    .addr_i, .wp_i, .tmr_exp_i(tmr_exp), .tmr_start_o(tmr_start),
    .tmr_run_o(tmr_run), .buf_wr_o(buf_wr), .buf_waddr_o(buf_waddr),
    .buf_wdata_o(buf_wdata), .buf_clr_o(buf_clr), .buf_rd_o(buf_rd),
    .buf_raddr_o(buf_raddr), .page_o(page), .idx_d_o(idx_d),
    .wel_o, .busy_o, .ready_o
  );

  pcc_timer #(.COMMIT_CYC(COMMIT_CYC)) u_tmr (
    .clk, .rst, .start_i(tmr_start), .run_i(tmr_run), .expired_o(tmr_exp)
  );

  pcc_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk, .rst, .wr_i(buf_wr), .waddr_i(buf_waddr), .wdata_i(buf_wdata),
    .clr_i(buf_clr), .rd_i(buf_rd), .raddr_i(buf_raddr),
    .rdata_o(arr_data_o), .rdirty_o(arr_we_o)
  );

  assign arr_addr_o = {page, idx_d};

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> busy_o);
  // R9
  wel_through_commit_chk: assert property (@(posedge clk) disable iff (rst)
    arr_we_o |-> wel_o);
endmodule

// File: tb/page_commit_ctrl_tb.sv
module page_commit_ctrl_tb;
  localparam int AW = 8, PB = 8, CC = 6;
  localparam int BUSY_LEN = CC + PB + 1;

  logic clk = 0, rst = 1;
  logic bit_wr = 0, bit_val = 0, rd_cyc = 0, rst_seq = 0, addr_ld = 0, wp = 1;
  logic [AW-1:0] addr = '0;
  logic wel, busy, ready, arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_data;

  always #2 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .COMMIT_CYC(CC)) u_dut (
    .clk, .rst, .bit_wr_i(bit_wr), .bit_val_i(bit_val), .rd_cyc_i(rd_cyc),
    .rst_seq_i(rst_seq), .addr_ld_i(addr_ld), .addr_i(addr), .wp_i(wp),
    .wel_o(wel), .busy_o(busy), .ready_o(ready), .arr_we_o(arr_we),
    .arr_addr_o(arr_addr), .arr_data_o(arr_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit fin = 0;

  // behavioural reference
  bit m_wel = 0;
  int m_phase = 0, m_bits = 0, m_sh = 0, m_off = 0, m_base = 0, m_left = 0;
  int q_off[$], q_dat[$];
  int m_exp_wr = 0, obs_wr = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] obs_mem [256];

  initial for (int i = 0; i < 256; i++) begin exp_mem[i] = 0; obs_mem[i] = 0; end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic m_fail(); m_phase = 0; m_wel = 0; endtask

  always @(posedge clk) begin
    if (rst) begin
      m_wel = 0; m_phase = 0; m_left = 0; q_off.delete(); q_dat.delete();
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) m_wel = 0;
    end else if (rst_seq) begin
      m_wel = 1; m_phase = 0; q_off.delete(); q_dat.delete();
    end else if (addr_ld) begin
      if (m_wel) begin
        m_phase = 1; m_base = int'(addr) / PB * PB; m_off = int'(addr) % PB;
        m_bits = 0; m_sh = 0; q_off.delete(); q_dat.delete();
      end
    end else if (rd_cyc) begin
      if (m_phase == 1) begin
        if (m_bits == 0 && q_off.size() > 0) m_phase = 2; else m_fail();
      end else if (m_phase == 2) m_fail();
      else if (m_phase == 3) begin
        if (wp && m_wel) begin
          bit seen [PB];
          for (int i = 0; i < PB; i++) seen[i] = 0;
          m_exp_wr = 0; obs_wr = 0;
          foreach (q_off[i]) begin
            exp_mem[m_base + q_off[i]] = 8'(q_dat[i]);
            if (!seen[q_off[i]]) begin seen[q_off[i]] = 1; m_exp_wr++; end
          end
          m_left = BUSY_LEN; m_phase = 0;
        end else m_fail();
      end
    end else if (bit_wr) begin
      if (m_phase == 1) begin
        m_sh = (m_sh * 2 + int'(bit_val)) % 256; m_bits++;
        if (m_bits == 8) begin
          q_off.push_back(m_off); q_dat.push_back(m_sh);
          m_off = (m_off + 1) % PB; m_bits = 0;
        end
      end else if (m_phase == 2) begin
        if (bit_val) m_phase = 3; else m_fail();
      end else if (m_phase == 3) m_fail();
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !fin) begin
      chk(wel == m_wel, "R2 latch", wel, m_wel);
      chk(busy == (m_left > 0), "R7 busy", busy, m_left > 0);
      chk(ready == !(m_left > 0), "R7 ready", ready, !(m_left > 0));
      if (arr_we) begin
        chk(m_left > 0, "R8 strobe outside busy", arr_we, 0);
        obs_mem[arr_addr] = arr_data;
        obs_wr++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !fin) begin
      fin = 1; checks++; errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wbit(input logic v); bit_wr = 1; bit_val = v; tick(); bit_wr = 0; endtask
  task automatic rd(); rd_cyc = 1; tick(); rd_cyc = 0; endtask
  task automatic rseq(); rst_seq = 1; tick(); rst_seq = 0; endtask
  task automatic aload(input int a); addr = AW'(a); addr_ld = 1; tick(); addr_ld = 0; endtask
  task automatic wbyte(input int b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
  endtask
  task automatic trailer(); rd(); wbit(1); rd(); endtask
  task automatic wait_idle();
    while (busy) tick();
    repeat (3) tick();
  endtask
  task automatic cmp_arr(input string tag);
    for (int i = 0; i < 256; i++)
      chk(obs_mem[i] === exp_mem[i], tag, obs_mem[i], exp_mem[i]);
    chk(obs_wr == m_exp_wr, {tag, " write count"}, obs_wr, m_exp_wr);
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk(wel == 0, "R1 latch", wel, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(ready == 1, "R1 ready", ready, 1);
    chk(arr_we == 0, "R1 strobe", arr_we, 0);
    rst = 0; tick();

    // R2 R3 R8: basic partial page at offset 3
    rseq();
    chk(wel == 1, "R2 latch set", wel, 1);
    aload(8'h13); wbyte(8'hA5); wbyte(8'h3C); wbyte(8'hFF);
    trailer();
    chk(busy == 1, "R7 busy start", busy, 1);
    wait_idle();
    cmp_arr("R3 R8 basic page");
    chk(wel == 0, "R9 latch after commit", wel, 0);

    // R4 wrap: 10 bytes from offset 6
    rseq(); aload(8'h2E);
    for (int k = 0; k < 10; k++) wbyte(8'h50 + k);
    trailer(); wait_idle();
    cmp_arr("R4 wrap page");

    // R2 no latch: address load ignored
    aload(8'h60); wbyte(8'h77); trailer(); tick();
    chk(busy == 0, "R2 no commit without latch", busy, 0);

    // R5 partial byte
    rseq(); aload(8'h60); wbyte(8'h77); for (int k = 0; k < 4; k++) wbit(1);
    trailer();
    chk(busy == 0, "R5 partial byte busy", busy, 0);
    chk(wel == 0, "R5 partial byte latch", wel, 0);

    // R5 write 0 after closing read
    rseq(); aload(8'h60); wbyte(8'h77); rd(); wbit(0);
    chk(wel == 0, "R5 write0 latch", wel, 0);

    // R5 zero bytes loaded
    rseq(); aload(8'h60); rd();
    chk(wel == 0, "R5 zero bytes latch", wel, 0);

    // R5 read/read
    rseq(); aload(8'h60); wbyte(8'h77); rd(); rd();
    chk(wel == 0, "R5 read read latch", wel, 0);

    // R5 data bit in place of final read
    rseq(); aload(8'h60); wbyte(8'h77); rd(); wbit(1); wbit(1);
    chk(wel == 0, "R5 bit for final read latch", wel, 0);

    // R6 write protect low blocks commit
    rseq(); aload(8'h60); wbyte(8'h77); rd(); wbit(1); wp = 0; rd();
    chk(busy == 0, "R6 wp blocks busy", busy, 0);
    chk(wel == 0, "R6 wp clears latch", wel, 0);
    wp = 1; tick();
    cmp_arr("R6 array untouched");

    // R6 R9: wp falls and events arrive during a commit
    rseq(); aload(8'h81); wbyte(8'hC3); wbyte(8'h18);
    trailer();
    wp = 0; rseq(); aload(8'h00); wbyte(8'h99); rd();
    chk(busy == 1, "R9 events ignored busy", busy, 1);
    wait_idle(); wp = 1;
    cmp_arr("R6 R9 commit under events");
    chk(wel == 0, "R9 latch cleared", wel, 0);

    // R10 reset sequence abandons a load
    rseq(); aload(8'hC0); wbyte(8'hEE); wbyte(8'hDD); rseq();
    trailer();
    chk(busy == 0, "R10 abandoned no busy", busy, 0);
    chk(wel == 1, "R10 latch kept", wel, 1);
    aload(8'hC5); wbyte(8'h42); trailer(); wait_idle();
    cmp_arr("R10 only new byte");

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule